// File: doc/BRIEF.md
# Single-bit Boolean accumulator processor

A small stored-program engine that evaluates Boolean formulas one step at a time. The program memory holds 32 words of 7 bits. A 5-bit program counter walks through it one word per cycle while execution is enabled. Each word either folds one of sixteen 1-bit variables into a 1-bit accumulator or copies the accumulator into one of those variables. The variables are named A to P.

The host writes the program through a load port while the run enable is low. It then resets the machine state, raises the run enable for exactly as many cycles as there are steps, and reads the result from the flat variable output. The block has no branches and no arithmetic. The counter runs straight through memory and wraps at the end.

Top module: `bitacc_core`

## Requirements
- R1: While reset is asserted, the program counter, the accumulator and all sixteen variables read 0. Program memory keeps the contents it had before reset.
- R2: A load-port write lands in program memory only when the run enable is low. A write offered while the run enable is high is dropped.
- R3: While the run enable is low, the program counter, the accumulator and the variables hold their values.
- R4: On each clock edge with the run enable high, exactly one word executes and the program counter advances by one. It goes from 31 back to 0.
- R5: Word layout: bit 6 set means a load-type step and clear means a store. Bits 5:4 hold the operation. Bits 3:0 name a variable: 0 is A, 1 is B and so on up to 15 for P. Bit k of the variable output is variable k.
- R6: Operation 00 on a load-type step copies the named variable into the accumulator.
- R7: Operation 01 on a load-type step puts the complement of the named variable into the accumulator.
- R8: Operation 10 on a load-type step ANDs the named variable into the accumulator.
- R9: Operation 11 on a load-type step ORs the named variable into the accumulator.
- R10: A store step writes the accumulator into the named variable. It leaves the accumulator and every other variable unchanged, whatever its operation field holds.
- R11: A load-type step leaves all sixteen variables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_en | input | 1 | Executes one word per cycle while high |
| ld_we | input | 1 | Program write strobe |
| ld_addr | input | 5 | Program write address |
| ld_data | input | 7 | Program word to write |
| acc_out | output | 1 | Accumulator |
| pc_out | output | 5 | Program counter |
| vars_out | output | 16 | Variables, bit k is variable k (A is bit 0) |

## Verification
The assertions assume that every word the counter reaches during a run has been written beforehand, so the word being executed and the variable it names are always defined. The bench keeps to this by loading every address it will execute before it raises the run enable. It holds the run enable for an exact number of cycles, so execution never runs into words that were not loaded. Programs build their constants from variable P, which no program ever writes, so P stays 0 after reset.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;
  localparam int unsigned NAME_W = 4;
  localparam int unsigned OP_W   = 2;
  localparam int unsigned WORD_W = 1 + OP_W + NAME_W;
  localparam int unsigned NVARS  = 1 << NAME_W;

  typedef enum logic [OP_W-1:0] {
    OP_COPY = 2'b00,
    OP_INV  = 2'b01,
    OP_AND  = 2'b10,
    OP_OR   = 2'b11
  } op_e;

  typedef struct packed {
    logic              is_load;
    op_e               op;
    logic [NAME_W-1:0] name;
  } word_t;
endpackage

// File: rtl/bitacc_rst_sync.sv
module bitacc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/bitacc_prog_store.sv
module bitacc_prog_store #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/bitacc_var_file.sv
module bitacc_var_file #(
  parameter int unsigned NAME_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [NAME_W-1:0]      waddr,
  input  logic                   wdata,
  output logic [(1<<NAME_W)-1:0] bits_q
);
  localparam int unsigned NV = 1 << NAME_W;

  logic [NV-1:0] bits_d;

  for (genvar i = 0; i < NV; i++) begin : g_bit
    always_comb begin
      bits_d[i] = bits_q[i];
      if (we && (waddr == NAME_W'(i))) begin
        bits_d[i] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[i] <= 1'b0;
      end else begin
        bits_q[i] <= bits_d[i];
      end
    end
  end
endmodule

// File: rtl/bitacc_exec.sv
module bitacc_exec
  import bitacc_pkg::*;
(
  input  word_t word,
  input  logic  acc,
  input  logic  var_bit,
  output logic  acc_nxt,
  output logic  store_req
);
  always_comb begin
    acc_nxt   = acc;
    store_req = 1'b0;
    if (word.is_load) begin
      unique case (word.op)
        OP_COPY: acc_nxt = var_bit;
        OP_INV:  acc_nxt = ~var_bit;
        OP_AND:  acc_nxt = acc & var_bit;
        OP_OR:   acc_nxt = acc | var_bit;
        default: acc_nxt = acc;
      endcase
    end else begin
      store_req = 1'b1;
    end
  end
endmodule

// File: rtl/bitacc_core.sv
module bitacc_core
  import bitacc_pkg::*;
#(
  parameter int unsigned PC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              ld_we,
  input  logic [PC_W-1:0]   ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              acc_out,
  output logic [PC_W-1:0]   pc_out,
  output logic [NVARS-1:0]  vars_out
);
  logic              rst_sync_n;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic              acc_q, acc_d;
  logic [WORD_W-1:0] cur_raw;
  word_t             cur_word;
  logic              acc_nxt;
  logic              store_req;
  logic              var_we;
  logic              mem_we;
  logic [NVARS-1:0]  vars_q;

  bitacc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign mem_we = ld_we & ~run_en;

  bitacc_prog_store #(.ADDR_W(PC_W), .DATA_W(WORD_W)) u_prog (
    .clk   (clk),
    .we    (mem_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q),
    .rdata (cur_raw)
  );

  assign cur_word = word_t'(cur_raw);

  bitacc_exec u_exec (
    .word      (cur_word),
    .acc       (acc_q),
    .var_bit   (vars_q[cur_word.name]),
    .acc_nxt   (acc_nxt),
    .store_req (store_req)
  );

  assign var_we = run_en & store_req;

  bitacc_var_file #(.NAME_W(NAME_W)) u_vars (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (var_we),
    .waddr  (cur_word.name),
    .wdata  (acc_q),
    .bits_q (vars_q)
  );

  always_comb begin
    pc_d  = pc_q;
    acc_d = acc_q;
    if (run_en) begin
      pc_d  = pc_q + PC_W'(1);
      acc_d = acc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q  <= '0;
      acc_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      acc_q <= acc_d;
    end
  end

  assign acc_out  = acc_q;
  assign pc_out   = pc_q;
  assign vars_out = vars_q;
endmodule

// File: rtl/bitacc_core_chk.sv
module bitacc_core_chk #(
  parameter int unsigned PC_W   = 5,
  parameter int unsigned WORD_W = 7,
  parameter int unsigned NVARS  = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              run_en,
  input logic [WORD_W-1:0] cur_raw,
  input logic              acc_out,
  input logic [PC_W-1:0]   pc_out,
  input logic [NVARS-1:0]  vars_out
);
  a_r4_pc_step: assert property (@(posedge clk) disable iff (!rst_ni)
    run_en |=> pc_out == PC_W'($past(pc_out) + PC_W'(1)));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_en |=> ($stable(pc_out) && $stable(acc_out) && $stable(vars_out)));

  a_r11_load_keeps_vars: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_en && cur_raw[WORD_W-1]) |=> $stable(vars_out));

  a_r10_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_en && !cur_raw[WORD_W-1]) |=> $stable(acc_out));

  a_r10_store_writes: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_en && !cur_raw[WORD_W-1]) |=> vars_out[$past(cur_raw[3:0])] == $past(acc_out));
endmodule

bind bitacc_core bitacc_core_chk #(.PC_W(PC_W), .WORD_W(bitacc_pkg::WORD_W), .NVARS(bitacc_pkg::NVARS)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .run_en   (run_en),
  .cur_raw  (cur_raw),
  .acc_out  (acc_out),
  .pc_out   (pc_out),
  .vars_out (vars_out)
);

// File: tb/bitacc_core_bench.sv
module bitacc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int VP = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0;
  logic        ld_we = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [6:0]  ld_data = '0;
  logic        acc_out;
  logic [4:0]  pc_out;
  logic [15:0] vars_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitacc_core u_bitacc_core (
    .clk (clk), .rst_n (rst_n), .run_en (run_en), .ld_we (ld_we),
    .ld_addr (ld_addr), .ld_data (ld_data),
    .acc_out (acc_out), .pc_out (pc_out), .vars_out (vars_out)
  );

  function automatic logic [6:0] enc(input bit ld, input int op, input int name);
    return {ld, 2'(op), 4'(name)};
  endfunction

  function automatic bit apply_op(input int op, input bit a, input bit v);
    case (op)
      0: return v;
      1: return ~v;
      2: return a & v;
      default: return a | v;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [6:0] w);
    ld_we = 1'b1; ld_addr = 5'(addr); ld_data = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input int n);
    run_en = 1'b1;
    repeat (n) @(negedge clk);
    run_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pc", pc_out, 0);
    chk("R1 acc", acc_out, 0);
    chk("R1 vars", vars_out, 0);
    do_reset();

    // Formula program: A becomes A xor (B and C); E = B&C, F = ~A&B&C
    for (int k = 0; k < 8; k++) begin
      bit a = k[0], b = k[1], c = k[2];
      do_reset();
      wr(0, enc(1, a ? 1 : 0, VP)); wr(1, enc(0, 0, 0));
      wr(2, enc(1, b ? 1 : 0, VP)); wr(3, enc(0, 0, 1));
      wr(4, enc(1, c ? 1 : 0, VP)); wr(5, enc(0, 0, 2));
      wr(6, enc(1, 0, 1));  wr(7, enc(1, 2, 2));  wr(8, enc(0, 0, 4));
      wr(9, enc(1, 1, 0));  wr(10, enc(1, 2, 4)); wr(11, enc(0, 0, 5));
      wr(12, enc(1, 1, 4)); wr(13, enc(1, 2, 0)); wr(14, enc(1, 3, 5));
      wr(15, enc(0, 0, 0));
      run(16);
      chk("R5 R6 R7 R8 R9 formula A", vars_out[0], a ^ (b & c));
      chk("R8 E", vars_out[4], b & c);
      chk("R7 R8 F", vars_out[5], (~a) & b & c);
      chk("R4 pc after 16", pc_out, 16);
    end

    // Operation sweep: acc=v, H=v, acc=a, acc=op(a,H), I=acc via store with junk op
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 4; k++) begin
        bit a = k[0], v = k[1], f;
        f = apply_op(op, a, v);
        do_reset();
        wr(0, enc(1, v ? 1 : 0, VP));
        wr(1, enc(0, 3 - op, 7));
        wr(2, enc(1, a ? 1 : 0, VP));
        wr(3, enc(1, op, 7));
        wr(4, enc(0, op, 8));
        run(5);
        chk("R6 R7 R8 R9 acc", acc_out, f);
        chk("R10 R11 vars", vars_out, (int'(v) << 7) | (int'(f) << 8));
        chk("R4 pc", pc_out, 5);
      end
    end

    // Wrap: every word is acc = not P
    do_reset();
    for (int i = 0; i < 32; i++) wr(i, enc(1, 1, VP));
    run(32);
    chk("R4 wrap pc", pc_out, 0);
    chk("R7 acc", acc_out, 1);
    run(1);
    chk("R4 pc after wrap", pc_out, 1);
    repeat (5) @(negedge clk);
    chk("R3 pc hold", pc_out, 1);
    chk("R3 acc hold", acc_out, 1);
    chk("R3 vars hold", vars_out, 0);

    // Write during run must be dropped
    run_en = 1'b1; ld_we = 1'b1; ld_addr = 5'd3; ld_data = enc(0, 0, 0);
    @(negedge clk);
    run_en = 1'b0; ld_we = 1'b0;
    do_reset();
    run(32);
    chk("R2 blocked write", vars_out[0], 0);

    // Reset keeps memory
    do_reset();
    chk("R1 pc", pc_out, 0);
    chk("R1 acc", acc_out, 0);
    run(1);
    chk("R1 memory kept", acc_out, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule